// File: doc/BRIEF.md
# Read/Write Request Scheduler with Hysteretic Write Draining

This block sits in front of the command stage of one DRAM bank or channel. It keeps pending reads in an 8-entry queue and pending writes in a separate 16-entry buffer. Every cycle it offers at most one request to the command stage. Reads and writes share a single data bus, and each change of bus direction costs idle time. For that reason writes are not sent one by one. They accumulate until the write buffer reaches a high occupancy mark, and then they leave as one burst until occupancy falls to a low mark.

Reads are ordered in one of two ways, chosen by a mode pin. In plain arrival order, the oldest read goes first. In row-hit-first order, the oldest read that targets the currently open row goes first, and the oldest read goes when there is no such hit. The open row is the row of the most recently issued request. Whenever the issued type changes between read and write, the scheduler holds back the offer until two cycles have passed with no issue.

All three data interfaces use valid/ready. An input request is taken on a clock edge where its valid and ready are both high. The input ready pins depend only on queue occupancy, never on the input valid pins. The issue offer is recomputed every cycle from registered state and the mode pin. While the offer waits for `iss_ready` it may change, for example when a drain begins or when a new row hit arrives. Nothing leaves a queue unless `iss_valid` and `iss_ready` are both high at an edge.

Top module: `rw_sched`

## Requirements
- R1: After reset both queues are empty, no row is open, `iss_valid` is 0, and `rd_in_ready` and `wr_in_ready` are 1.
- R2: `rd_in_ready` is 1 exactly when fewer than 8 reads are held. A read presented while it is 0 is not stored.
- R3: `wr_in_ready` is 1 exactly when fewer than 16 writes are held. A write presented while it is 0 is not stored.
- R4: A drain begins in the first cycle in which write occupancy is 12 or more.
- R5: During a drain, only writes are offered (`iss_write`=1), in arrival order. The drain lasts until occupancy is 4 or less, and that cycle is no longer draining.
- R6: Outside a drain no write is offered, even with reads absent. During a drain no read is offered.
- R7: With `frfcfs_en`=0, the offered read is the oldest held read.
- R8: With `frfcfs_en`=1 and no held read on the open row, the offered read is the oldest held read.
- R9: With `frfcfs_en`=1, the offered read is the oldest held read whose row equals the open row. The open row is the row of the last issued read or write.
- R10: An offer whose type differs from the last issued type is withheld until at least 2 cycles without an issue have followed that last issue.
- R11: While `iss_ready` is 0, no request is removed and the open row and last type stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frfcfs_en | input | 1 | 1 selects row-hit-first read ordering, 0 selects arrival order |
| rd_in_valid | input | 1 | Read request present |
| rd_in_ready | output | 1 | Read queue can accept a request |
| rd_in_row | input | 8 | Row addressed by the read |
| rd_in_tag | input | 8 | Identifier carried with the read |
| wr_in_valid | input | 1 | Write request present |
| wr_in_ready | output | 1 | Write buffer can accept a request |
| wr_in_row | input | 8 | Row addressed by the write |
| wr_in_tag | input | 8 | Identifier carried with the write |
| iss_valid | output | 1 | A request is offered to the command stage |
| iss_ready | input | 1 | Command stage takes the offered request |
| iss_write | output | 1 | 1 when the offer is a write, 0 for a read |
| iss_row | output | 8 | Row of the offered request |
| iss_tag | output | 8 | Identifier of the offered request |

## Verification
All outputs are combinational from registered state, plus the mode pin for the read choice. A request accepted at edge k can therefore be offered no earlier than the cycle after edge k. A write accept that brings occupancy to 12 starts the drain in that same following cycle. An opposite-type offer appears in the third cycle after the issuing edge, provided nothing issued in between. The bench drives inputs just after each falling edge and lets them settle. It then compares the offer and both ready pins against a queue-based reference model for the cycle in progress. Only after the comparison does it advance the model by what the coming rising edge will do. Each comparison is therefore made against the state produced by every edge already taken, one cycle at a time.

// File: rtl/rws_pkg.sv
package rws_pkg;
  localparam int ROW_W = 8;
  localparam int TAG_W = 8;

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [TAG_W-1:0] tag;
  } req_t;
endpackage

// File: rtl/rws_rd_queue.sv
module rws_rd_queue
  import rws_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  req_t                       push_req,
  input  logic                       pop,
  input  logic                       frfcfs,
  input  logic                       open_v,
  input  logic [ROW_W-1:0]           open_row,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output req_t                       sel_req,
  output logic                       any_hit,
  output logic                       full
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  req_t            slot [DEPTH];
  logic [CW-1:0]   cnt;
  logic [DEPTH-1:0] hit;
  logic [IW-1:0]   hit_idx;
  logic [IW-1:0]   sel;
  logic [CW-1:0]   wpos;

  // Slot 0 is always the oldest entry; a lower index means earlier arrival.
  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = (CW'(g) < cnt) && open_v && (slot[g].row == open_row);
  end

  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_idx = IW'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign sel     = (frfcfs && any_hit) ? hit_idx : '0;
  assign sel_req = slot[sel];
  assign count   = cnt;
  assign full    = (cnt == CW'(DEPTH));
  assign wpos    = cnt - CW'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH-1; i++) begin
          if (IW'(i) >= sel) slot[i] <= slot[i+1];
        end
      end
      if (push) slot[wpos[IW-1:0]] <= push_req;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt == $past(cnt) + CW'(1)));
  assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/rws_wr_buf.sv
module rws_wr_buf
  import rws_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  req_t                       push_req,
  input  logic                       pop,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output req_t                       head_req,
  output logic                       full
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  req_t          mem [DEPTH];
  logic [IW-1:0] head, tail;
  logic [CW-1:0] cnt;

  assign count    = cnt;
  assign head_req = mem[head];
  assign full     = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[tail] <= push_req;
        tail      <= (tail == IW'(DEPTH-1)) ? '0 : tail + IW'(1);
      end
      if (pop) head <= (head == IW'(DEPTH-1)) ? '0 : head + IW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt == $past(cnt) + CW'(1)));
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/rws_drain_ctl.sv
module rws_drain_ctl #(
  parameter int DEPTH = 16,
  parameter int HI    = 12,
  parameter int LO    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] occ,
  output logic                       active
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] HI_V = CW'(HI);
  localparam logic [CW-1:0] LO_V = CW'(LO);

  logic flag_q;

  // Hysteresis: enter at the high mark, stay until the low mark is reached.
  assign active = flag_q ? (occ > LO_V) : (occ >= HI_V);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= active;
  end

  assert_drain_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (occ >= HI_V));
  assert_drain_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (occ <= LO_V));
endmodule

// File: rtl/rws_bus_turn.sv
module rws_bus_turn #(
  parameter int TA = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_write,
  input  logic fire,
  input  logic fire_write,
  output logic allow
);
  localparam int GW = $clog2(TA+1);
  localparam logic [GW-1:0] TA_V = GW'(TA);

  logic          last_v, last_w;
  logic [GW-1:0] gap;

  // Cycles since the last issue, saturating at the penalty length.
  assign allow = !(last_v && (want_write != last_w) && (gap < TA_V));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_v <= 1'b0;
      last_w <= 1'b0;
      gap    <= '0;
    end else if (fire) begin
      last_v <= 1'b1;
      last_w <= fire_write;
      gap    <= '0;
    end else if (gap < TA_V) begin
      gap <= gap + GW'(1);
    end
  end

  assert_turn_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_v && (fire_write != last_w)) |-> !$past(fire));
endmodule

// File: rtl/rw_sched.sv
module rw_sched
  import rws_pkg::*;
#(
  parameter int RD_DEPTH = 8,
  parameter int WR_DEPTH = 16,
  parameter int WR_HI    = 12,
  parameter int WR_LO    = 4,
  parameter int TURN     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frfcfs_en,
  input  logic             rd_in_valid,
  output logic             rd_in_ready,
  input  logic [ROW_W-1:0] rd_in_row,
  input  logic [TAG_W-1:0] rd_in_tag,
  input  logic             wr_in_valid,
  output logic             wr_in_ready,
  input  logic [ROW_W-1:0] wr_in_row,
  input  logic [TAG_W-1:0] wr_in_tag,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic             iss_write,
  output logic [ROW_W-1:0] iss_row,
  output logic [TAG_W-1:0] iss_tag
);
  localparam int RCW = $clog2(RD_DEPTH+1);
  localparam int WCW = $clog2(WR_DEPTH+1);

  logic [RCW-1:0]   rd_cnt;
  logic [WCW-1:0]   wr_cnt;
  req_t             rd_sel, wr_head;
  logic             rd_full, wr_full, rd_hit;
  logic             draining, have_cand, allow, fire;
  logic             rd_push, wr_push, rd_pop, wr_pop;
  logic             open_v;
  logic [ROW_W-1:0] open_row;

  assign rd_in_ready = !rd_full;
  assign wr_in_ready = !wr_full;
  assign rd_push     = rd_in_valid && rd_in_ready;
  assign wr_push     = wr_in_valid && wr_in_ready;

  rws_rd_queue #(.DEPTH(RD_DEPTH)) u_rdq (
    .clk(clk), .rst_n(rst_n),
    .push(rd_push), .push_req('{row: rd_in_row, tag: rd_in_tag}),
    .pop(rd_pop), .frfcfs(frfcfs_en), .open_v(open_v), .open_row(open_row),
    .count(rd_cnt), .sel_req(rd_sel), .any_hit(rd_hit), .full(rd_full)
  );

  rws_wr_buf #(.DEPTH(WR_DEPTH)) u_wrb (
    .clk(clk), .rst_n(rst_n),
    .push(wr_push), .push_req('{row: wr_in_row, tag: wr_in_tag}),
    .pop(wr_pop), .count(wr_cnt), .head_req(wr_head), .full(wr_full)
  );

  rws_drain_ctl #(.DEPTH(WR_DEPTH), .HI(WR_HI), .LO(WR_LO)) u_drain (
    .clk(clk), .rst_n(rst_n), .occ(wr_cnt), .active(draining)
  );

  rws_bus_turn #(.TA(TURN)) u_turn (
    .clk(clk), .rst_n(rst_n), .want_write(draining),
    .fire(fire), .fire_write(iss_write), .allow(allow)
  );

  // Draining owns the bus; otherwise only reads may go.
  assign have_cand = draining ? (wr_cnt != '0) : (rd_cnt != '0);
  assign iss_valid = have_cand && allow;
  assign iss_write = draining;
  assign iss_row   = draining ? wr_head.row : rd_sel.row;
  assign iss_tag   = draining ? wr_head.tag : rd_sel.tag;
  assign fire      = iss_valid && iss_ready;
  assign rd_pop    = fire && !iss_write;
  assign wr_pop    = fire && iss_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_v   <= 1'b0;
      open_row <= '0;
    end else if (fire) begin
      open_v   <= 1'b1;
      open_row <= iss_row;
    end
  end

  assert_write_only_in_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_write) |-> (wr_cnt > WCW'(WR_LO)));
  assert_hit_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_write && frfcfs_en && rd_hit) |-> (open_v && iss_row == open_row));
  assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (open_row == $past(open_row)));
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !iss_valid);
endmodule

// File: tb/rw_sched_test.sv
module rw_sched_test;
  import rws_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, frfcfs_en;
  logic             rd_in_valid, rd_in_ready, wr_in_valid, wr_in_ready;
  logic [ROW_W-1:0] rd_in_row, wr_in_row, iss_row;
  logic [TAG_W-1:0] rd_in_tag, wr_in_tag, iss_tag;
  logic             iss_valid, iss_ready, iss_write;

  rw_sched uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model: plain queues, arrival order by position.
  int rq_row[$], rq_tag[$], wq_row[$], wq_tag[$];
  bit drain_f, last_v, last_d, open_v, prev_stall;
  int gap, open_r, tag_ctr;
  bit ex_active, ex_valid, ex_write, ex_block, ex_hit;
  int ex_row, ex_tag, ex_idx;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compute_exp();
    bit have;
    ex_active = drain_f ? (wq_row.size() > 4) : (wq_row.size() >= 12);
    have      = ex_active ? (wq_row.size() > 0) : (rq_row.size() > 0);
    ex_write  = ex_active;
    ex_block  = have && last_v && (ex_write != last_d) && (gap < 2);
    ex_valid  = have && !ex_block;
    ex_hit = 0; ex_idx = 0;
    if (!ex_active && frfcfs_en && open_v) begin
      // R9: oldest read on the open row; open row follows the last issue
      foreach (rq_row[i]) if (!ex_hit && rq_row[i] == open_r) begin ex_hit = 1; ex_idx = i; end
    end
    if (ex_write) begin ex_row = wq_row.size() ? wq_row[0] : 0; ex_tag = wq_row.size() ? wq_tag[0] : 0; end
    else begin ex_row = rq_row.size() ? rq_row[ex_idx] : 0; ex_tag = rq_row.size() ? rq_tag[ex_idx] : 0; end
  endtask

  function automatic string pick_label();
    if (prev_stall) return "R11";
    if (ex_block) return "R10";
    if (ex_active && !drain_f) return "R4";
    if (ex_write) return "R5";
    if (wq_row.size() > 0) return "R6";
    if (ex_valid && frfcfs_en && ex_hit) return "R9";
    if (ex_valid && frfcfs_en) return "R8";
    if (ex_valid) return "R7";
    return "R1";
  endfunction

  task automatic step(int pr, int pw, int prdy, int rows);
    int rs, ws;
    string lbl;
    @(negedge clk);
    rd_in_valid = ($urandom_range(0, 99) < pr);
    wr_in_valid = ($urandom_range(0, 99) < pw);
    iss_ready   = ($urandom_range(0, 99) < prdy);
    rd_in_row   = ROW_W'($urandom_range(0, rows-1));
    wr_in_row   = ROW_W'($urandom_range(0, rows-1));
    rd_in_tag   = TAG_W'(tag_ctr);
    wr_in_tag   = TAG_W'(tag_ctr + 1);
    tag_ctr += 2;
    #1;
    compute_exp();
    lbl = pick_label();
    chk(lbl, int'(iss_valid), int'(ex_valid), "iss_valid");
    if (ex_valid && iss_valid) begin
      chk(lbl, int'(iss_write), int'(ex_write), "iss_write");
      chk(lbl, int'(iss_row), ex_row, "iss_row");
      chk(lbl, int'(iss_tag), ex_tag & 8'hff, "iss_tag");
    end
    chk("R2", int'(rd_in_ready), int'(rq_row.size() < 8), "rd_in_ready");
    chk("R3", int'(wr_in_ready), int'(wq_row.size() < 16), "wr_in_ready");
    // advance model by what the next rising edge does
    rs = rq_row.size(); ws = wq_row.size();
    if (ex_valid && iss_ready) begin
      if (ex_write) begin void'(wq_row.pop_front()); void'(wq_tag.pop_front()); end
      else begin rq_row.delete(ex_idx); rq_tag.delete(ex_idx); end
      open_v = 1; open_r = ex_row; last_v = 1; last_d = ex_write; gap = 0;
    end else if (gap < 2) gap++;
    drain_f = ex_active;
    prev_stall = ex_valid && !iss_ready;
    if (rd_in_valid && rs < 8) begin rq_row.push_back(int'(rd_in_row)); rq_tag.push_back(int'(rd_in_tag)); end
    if (wr_in_valid && ws < 16) begin wq_row.push_back(int'(wr_in_row)); wq_tag.push_back(int'(wr_in_tag)); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; frfcfs_en = 0; rd_in_valid = 0; wr_in_valid = 0; iss_ready = 0;
    rd_in_row = '0; wr_in_row = '0; rd_in_tag = '0; wr_in_tag = '0;
    tag_ctr = 1; gap = 0; drain_f = 0; last_v = 0; last_d = 0; open_v = 0; open_r = 0; prev_stall = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(iss_valid), 0, "iss_valid in reset");
    chk("R1", int'(rd_in_ready), 1, "rd_in_ready in reset");
    chk("R1", int'(wr_in_ready), 1, "wr_in_ready in reset");
    rst_n = 1;
    // R7: arrival order, reads only
    frfcfs_en = 0;
    repeat (200) step(50, 0, 60, 4);
    // R8/R9: row-hit-first with a backlog
    frfcfs_en = 1;
    repeat (300) step(60, 0, 35, 3);
    // R2: fill the read queue with the command stage stalled
    repeat (20) step(100, 0, 0, 4);
    // R4/R5/R6/R10: write pressure with reads mixed in
    repeat (600) step(40, 60, 80, 3);
    // R3: fill the write buffer while stalled
    repeat (24) step(0, 100, 0, 4);
    frfcfs_en = 0;
    repeat (400) step(50, 50, 50, 5);
    frfcfs_en = 1;
    repeat (400) step(30, 70, 70, 2);
    repeat (60) step(0, 0, 100, 2);
    finish_run();
  end
endmodule